// File: doc/BRIEF.md
# Protection Entry Register Bank with Write Locking

This block holds the programming state of a set of memory-protection entries. Each entry stores an 8-bit configuration byte and an XLEN-wide address register. One security-policy register sits beside them. Software reaches the bank by CSR index through one port. A single write strobe, a register-class select and an index pick the target. Configuration bytes are packed several to a CSR word, and read data is formed combinationally from the stored values.

Every write is filtered before it lands. Three things can silently drop a write: an entry's own lock flag, a locked neighbour that uses top-of-range matching, and the lockdown policy in the security register. A bypass bit in the security register can override entry locks for configuration writes. The lockdown and whitelist policy bits are sticky. All stored configuration and address values are driven out in flat buses for the range decoder and the access checker that follow.

Top module: `prot_csr_bank`

## Requirements
- R1: After an active-low reset, every configuration byte, every address register and the security register read as zero.
- R2: Select value 0 addresses packed configuration words. Byte j (wdata bits [8j+7:8j]) of word n belongs to entry 4n+j. Configuration bit 7 is lock, bits [4:3] are the match mode (01 = top-of-range), and bit 2 is execute, bit 1 write, bit 0 read. Reads return the same packing, and bytes with no implemented entry read as zero.
- R3: With bypass and lockdown both clear, a configuration write to an entry whose lock bit is set leaves that byte unchanged. Other bytes of the same word are still written.
- R4: With bypass set (security bit 2), every configuration byte write is accepted, locked or not.
- R5: With lockdown set (security bit 0) and bypass clear, a byte is accepted only in two cases: it sets lock with execute clear, or it has lock clear and its low three bits are not 3'b110. Otherwise it is dropped, whether or not the entry is locked.
- R6: Select value 1 addresses entry address registers by index. A write to an entry whose own lock bit is set is ignored.
- R7: An address write to entry i is also ignored when entry i+1 is locked with mode 01. A locked neighbour in any other mode does not block the write.
- R8: Select value 2 addresses the security register: bit 0 lockdown, bit 1 whitelist, bit 2 bypass. Bypass cannot go from 0 to 1 while any entry is locked.
- R9: Once set, the lockdown and whitelist bits stay set until reset.
- R10: Address and configuration indices beyond the implemented entries are ignored on write and read as zero. Select value 3 reads zero and ignores writes.
- R11: While the write strobe is low, no stored value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_we_i | input | 1 | Write strobe |
| csr_sel_i | input | 2 | Register class: 0 config word, 1 address, 2 security, 3 none |
| csr_idx_i | input | IDX_W | Word or entry index |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data for sel/idx |
| cfg_o | output | N*8 | All configuration bytes, entry e at [8e+7:8e] |
| addr_o | output | N*XLEN | All address registers, entry e at [XLEN*e+XLEN-1:XLEN*e] |
| sec_o | output | 3 | Security register {bypass, whitelist, lockdown} |

## Verification
In a single cycle, one packed configuration write can set the lock on one entry and rewrite a neighbouring entry. Each byte must be judged against the lock state stored before the clock edge, not against the locks the same word is setting. The bench provokes this with words that lock one entry while changing another, including words that set a top-of-range lock on the next entry. It then checks the following address write against that newly stored lock. Random mixes of configuration, address and security writes are compared after every operation against a bench model built from the requirements.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  localparam int unsigned CFG_LOCK   = 7;
  localparam int unsigned CFG_MODE_L = 3;
  localparam int unsigned CFG_X      = 2;
  localparam logic [1:0]  MODE_TOR   = 2'b01;
  localparam logic [2:0]  PERM_WX    = 3'b110;

  localparam int unsigned SEC_W         = 3;
  localparam int unsigned SEC_LOCKDOWN  = 0;
  localparam int unsigned SEC_WHITELIST = 1;
  localparam int unsigned SEC_BYPASS    = 2;

  localparam int unsigned ENT_PER_IDX = 4;  // entry stride between config words
endpackage

// File: rtl/prot_cfg_gate.sv
module prot_cfg_gate
  import prot_csr_pkg::*;
(
  input  logic [7:0] old_cfg_i,
  input  logic [7:0] new_cfg_i,
  input  logic       lockdown_i,
  input  logic       bypass_i,
  output logic       accept_o
);
  logic set_lock_no_x;
  logic shared_ok;

  always_comb begin
    set_lock_no_x = new_cfg_i[CFG_LOCK] && !new_cfg_i[CFG_X];
    shared_ok     = !new_cfg_i[CFG_LOCK] && (new_cfg_i[2:0] != PERM_WX);
    accept_o      = bypass_i
                 || (!lockdown_i && !old_cfg_i[CFG_LOCK])
                 || (lockdown_i && (set_lock_no_x || shared_ok));
  end
endmodule

// File: rtl/prot_entry.sv
module prot_entry
  import prot_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  input  logic            addr_we_i,
  input  logic [XLEN-1:0] addr_wdata_i,
  input  logic            lockdown_i,
  input  logic            bypass_i,
  input  logic [7:0]      next_cfg_i,
  output logic [7:0]      cfg_o,
  output logic [XLEN-1:0] addr_o
);
  logic       cfg_ok;
  logic       addr_ok;
  logic [7:0] cfg_q;
  logic [XLEN-1:0] addr_q;

  prot_cfg_gate u_gate (
    .old_cfg_i  (cfg_q),
    .new_cfg_i  (cfg_wdata_i),
    .lockdown_i (lockdown_i),
    .bypass_i   (bypass_i),
    .accept_o   (cfg_ok)
  );

  // neighbour in top-of-range mode uses this address as its base
  always_comb begin
    addr_ok = !cfg_q[CFG_LOCK]
           && !(next_cfg_i[CFG_LOCK] && next_cfg_i[CFG_MODE_L+:2] == MODE_TOR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_we_i && cfg_ok)   cfg_q  <= cfg_wdata_i;
      if (addr_we_i && addr_ok) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/prot_sec_reg.sv
module prot_sec_reg
  import prot_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic             any_lock_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] sec_d;

  always_comb begin
    sec_d = wdata_i;
    if (!sec_q[SEC_BYPASS] && any_lock_i) sec_d[SEC_BYPASS] = 1'b0;
    sec_d[SEC_LOCKDOWN]  = sec_d[SEC_LOCKDOWN]  | sec_q[SEC_LOCKDOWN];
    sec_d[SEC_WHITELIST] = sec_d[SEC_WHITELIST] | sec_q[SEC_WHITELIST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sec_q <= '0;
    else if (we_i) sec_q <= sec_d;
  end

  assign sec_o = sec_q;
endmodule

// File: rtl/prot_csr_bank.sv
module prot_csr_bank
  import prot_csr_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                csr_we_i,
  input  logic [1:0]          csr_sel_i,
  input  logic [IDX_W-1:0]    csr_idx_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic [N*8-1:0]      cfg_o,
  output logic [N*XLEN-1:0]   addr_o,
  output logic [SEC_W-1:0]    sec_o
);
  localparam int unsigned BPW   = XLEN / 8;  // config bytes per word
  localparam int unsigned ENT_W = IDX_W + 3;

  csr_sel_e         sel;
  logic [7:0]       cfg_q   [N];
  logic [XLEN-1:0]  addr_q  [N];
  logic [N-1:0]     cfg_we;
  logic [7:0]       cfg_wb  [N];
  logic [N-1:0]     addr_we;
  logic [N-1:0]     lock_v;
  logic [SEC_W-1:0] sec_q;

  assign sel = csr_sel_e'(csr_sel_i);

  function automatic logic [ENT_W-1:0] ent_of(input logic [IDX_W-1:0] idx, input int unsigned j);
    return ENT_W'(idx) * ENT_W'(ENT_PER_IDX) + ENT_W'(j);
  endfunction

  always_comb begin
    for (int e = 0; e < N; e++) begin
      cfg_we[e]  = 1'b0;
      cfg_wb[e]  = '0;
      addr_we[e] = csr_we_i && sel == SEL_ADDR && ENT_W'(csr_idx_i) == ENT_W'(e);
      for (int j = 0; j < BPW; j++) begin
        if (csr_we_i && sel == SEL_CFG && ent_of(csr_idx_i, j) == ENT_W'(e)) begin
          cfg_we[e] = 1'b1;
          cfg_wb[e] = csr_wdata_i[j*8+:8];
        end
      end
    end
  end

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [7:0] next_cfg;
    if (e + 1 < N) begin : g_next
      assign next_cfg = cfg_q[e+1];
    end else begin : g_last
      assign next_cfg = 8'h00;
    end

    prot_entry #(.XLEN(XLEN)) u_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cfg_we_i     (cfg_we[e]),
      .cfg_wdata_i  (cfg_wb[e]),
      .addr_we_i    (addr_we[e]),
      .addr_wdata_i (csr_wdata_i),
      .lockdown_i   (sec_q[SEC_LOCKDOWN]),
      .bypass_i     (sec_q[SEC_BYPASS]),
      .next_cfg_i   (next_cfg),
      .cfg_o        (cfg_q[e]),
      .addr_o       (addr_q[e])
    );

    assign lock_v[e]              = cfg_q[e][CFG_LOCK];
    assign cfg_o[e*8+:8]          = cfg_q[e];
    assign addr_o[e*XLEN+:XLEN]   = addr_q[e];
  end

  prot_sec_reg u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (csr_we_i && sel == SEL_SEC),
    .wdata_i    (csr_wdata_i[SEC_W-1:0]),
    .any_lock_i (|lock_v),
    .sec_o      (sec_q)
  );

  assign sec_o = sec_q;

  always_comb begin
    csr_rdata_o = '0;
    unique case (sel)
      SEL_CFG: begin
        for (int j = 0; j < BPW; j++) begin
          for (int e = 0; e < N; e++) begin
            if (ent_of(csr_idx_i, j) == ENT_W'(e)) csr_rdata_o[j*8+:8] = cfg_q[e];
          end
        end
      end
      SEL_ADDR: begin
        for (int e = 0; e < N; e++) begin
          if (ENT_W'(csr_idx_i) == ENT_W'(e)) csr_rdata_o = addr_q[e];
        end
      end
      SEL_SEC:  csr_rdata_o[SEC_W-1:0] = sec_q;
      default:  csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prot_csr_chk.sv
module prot_csr_chk
  import prot_csr_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                csr_we_i,
  input logic [1:0]          csr_sel_i,
  input logic [IDX_W-1:0]    csr_idx_i,
  input logic [XLEN-1:0]     csr_wdata_i,
  input logic [XLEN-1:0]     csr_rdata_o,
  input logic [N*8-1:0]      cfg_o,
  input logic [N*XLEN-1:0]   addr_o,
  input logic [SEC_W-1:0]    sec_o
);
  logic any_lock;
  always_comb begin
    any_lock = 1'b0;
    for (int e = 0; e < N; e++) any_lock = any_lock | cfg_o[e*8+CFG_LOCK];
  end

  // R9
  lockdown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o[SEC_LOCKDOWN] |=> sec_o[SEC_LOCKDOWN]);

  // R9
  whitelist_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o[SEC_WHITELIST] |=> sec_o[SEC_WHITELIST]);

  // R8
  bypass_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_o[SEC_BYPASS] && any_lock) |=> !sec_o[SEC_BYPASS]);

  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> ($stable(cfg_o) && $stable(addr_o) && $stable(sec_o)));

  // R10
  oob_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == 2'd1 && 32'(csr_idx_i) >= N) |-> csr_rdata_o == '0);

  for (genvar e = 0; e < N; e++) begin : g_ent
    // R3
    cfg_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_o[e*8+CFG_LOCK] && !sec_o[SEC_BYPASS] && !sec_o[SEC_LOCKDOWN])
        |=> $stable(cfg_o[e*8+:8]));

    // R6
    addr_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[e*8+CFG_LOCK] |=> $stable(addr_o[e*XLEN+:XLEN]));
  end
endmodule

bind prot_csr_bank prot_csr_chk #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_prot_csr_bank.sv
module tb_prot_csr_bank;
  localparam int unsigned N     = 8;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IDX_W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              csr_we_i = 1'b0;
  logic [1:0]        csr_sel_i = 2'd3;
  logic [IDX_W-1:0]  csr_idx_i = '0;
  logic [XLEN-1:0]   csr_wdata_i = '0;
  logic [XLEN-1:0]   csr_rdata_o;
  logic [N*8-1:0]    cfg_o;
  logic [N*XLEN-1:0] addr_o;
  logic [2:0]        sec_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0]      m_cfg  [N];
  logic [XLEN-1:0] m_addr [N];
  logic [2:0]      m_sec;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prot_csr_bank #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) dut (.*);

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, input int idx, output logic [XLEN-1:0] d);
    csr_sel_i = sel;
    csr_idx_i = IDX_W'(idx);
    #1;
    d = csr_rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    csr_we_i = 1'b0;
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    m_sec = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [XLEN-1:0] exp_read(input logic [1:0] sel, input int idx);
    logic [XLEN-1:0] r = '0;
    if (sel == 2'd0) begin
      for (int j = 0; j < XLEN/8; j++) if (idx*4 + j < N) r[j*8+:8] = m_cfg[idx*4+j];
    end else if (sel == 2'd1) begin
      if (idx < N) r = m_addr[idx];
    end else if (sel == 2'd2) begin
      r[2:0] = m_sec;
    end
    return r;
  endfunction

  task automatic model_write(input logic [1:0] sel, input int idx, input logic [XLEN-1:0] d);
    logic [7:0] old_cfg [N];
    logic any_lock = 1'b0;
    for (int e = 0; e < N; e++) begin old_cfg[e] = m_cfg[e]; any_lock |= m_cfg[e][7]; end
    if (sel == 2'd0) begin
      for (int j = 0; j < XLEN/8; j++) begin
        int e = idx*4 + j;
        logic [7:0] b = d[j*8+:8];
        bit ok;
        if (e < N) begin
          ok = m_sec[2] || (!m_sec[0] && !old_cfg[e][7]) ||
               (m_sec[0] && ((b[7] && !b[2]) || (!b[7] && b[2:0] != 3'b110)));
          if (ok) m_cfg[e] = b;
        end
      end
    end else if (sel == 2'd1) begin
      if (idx < N && !old_cfg[idx][7] &&
          !(idx + 1 < N && old_cfg[idx+1][7] && old_cfg[idx+1][4:3] == 2'b01))
        m_addr[idx] = d;
    end else if (sel == 2'd2) begin
      logic [2:0] nv = d[2:0];
      if (!m_sec[2] && any_lock) nv[2] = 1'b0;
      nv[1:0] = nv[1:0] | m_sec[1:0];
      m_sec = nv;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int idx, input logic [XLEN-1:0] d);
    @(negedge clk_i);
    csr_we_i = 1'b1; csr_sel_i = sel; csr_idx_i = IDX_W'(idx); csr_wdata_i = d;
    @(negedge clk_i);
    csr_we_i = 1'b0;
    model_write(sel, idx, d);
  endtask

  task automatic idle(input logic [1:0] sel, input int idx, input logic [XLEN-1:0] d);
    @(negedge clk_i);
    csr_we_i = 1'b0; csr_sel_i = sel; csr_idx_i = IDX_W'(idx); csr_wdata_i = d;
    @(negedge clk_i);
  endtask

  task automatic check_all(input string req);
    logic [XLEN-1:0] d;
    for (int i = 0; i < 3; i++) begin rd(2'd0, i, d); chk(req, d, exp_read(2'd0, i)); end
    for (int i = 0; i < N + 2; i++) begin rd(2'd1, i, d); chk(req, d, exp_read(2'd1, i)); end
    rd(2'd2, 0, d); chk(req, d, exp_read(2'd2, 0));
    rd(2'd3, 0, d); chk(req, d, '0);
  endtask

  task automatic chk_one(input string req, input logic [1:0] sel, input int idx, input logic [XLEN-1:0] exp);
    logic [XLEN-1:0] d;
    rd(sel, idx, d);
    chk(req, d, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_all("R1 reset");

    // R2 packing and R10 absent word
    wr(2'd0, 0, 32'h44332211);
    wr(2'd0, 1, 32'h07060504);
    wr(2'd0, 2, 32'hDEADBEEF);
    chk_one("R2 word0", 2'd0, 0, 32'h44332211);
    chk_one("R2 word1", 2'd0, 1, 32'h07060504);
    chk_one("R10 cfg oob", 2'd0, 2, 32'h0);
    chk(        "R2 cfg bus entry5", 32'(cfg_o[5*8+:8]), 32'h05);
    wr(2'd1, N, 32'h12345678);
    chk_one("R10 addr oob", 2'd1, N, 32'h0);
    wr(2'd3, 0, 32'hFFFFFFFF);
    check_all("R10 sel3");

    // R3 lock holds byte, others written
    do_reset();
    wr(2'd0, 0, 32'h00000080);
    wr(2'd0, 0, 32'h01010101);
    chk_one("R3 locked byte", 2'd0, 0, 32'h01010180);
    // R8 bypass refused while locked
    wr(2'd2, 0, 32'h4);
    chk_one("R8 bypass", 2'd2, 0, 32'h0);
    // R6 own lock / R7 TOR neighbour
    wr(2'd1, 0, 32'hAAAA0000);
    chk_one("R6 own lock", 2'd1, 0, 32'h0);
    wr(2'd1, 1, 32'h11110000);
    chk_one("R6 unlocked", 2'd1, 1, 32'h11110000);
    wr(2'd0, 0, 32'h88000000);   // entry3 locked, TOR
    wr(2'd0, 1, 32'h00009000);   // entry5 locked, other mode
    wr(2'd1, 2, 32'h22220000);
    chk_one("R7 tor next", 2'd1, 2, 32'h0);
    wr(2'd1, 4, 32'h44440000);
    chk_one("R7 non-tor next", 2'd1, 4, 32'h44440000);
    check_all("R7 state");

    // R4 bypass overrides lock
    do_reset();
    wr(2'd2, 0, 32'h4);
    chk_one("R4 bypass set", 2'd2, 0, 32'h4);
    wr(2'd0, 0, 32'h00000080);
    wr(2'd0, 0, 32'h00000000);
    chk_one("R4 unlocked by bypass", 2'd0, 0, 32'h0);

    // R9 sticky
    wr(2'd2, 0, 32'h3);
    wr(2'd2, 0, 32'h0);
    chk_one("R9 sticky", 2'd2, 0, 32'h3);

    // R5 lockdown exceptions
    do_reset();
    wr(2'd2, 0, 32'h1);
    wr(2'd0, 0, 32'h00000081);
    chk_one("R5 lock no x", 2'd0, 0, 32'h00000081);
    wr(2'd0, 0, 32'h00000085);
    chk_one("R5 lock with x", 2'd0, 0, 32'h00000081);
    wr(2'd0, 0, 32'h00000003);
    chk_one("R5 shared ok", 2'd0, 0, 32'h00000003);
    wr(2'd0, 0, 32'h00000603);
    chk_one("R5 wx refused", 2'd0, 0, 32'h00000003);

    // R11 idle, plus mixed sweep
    idle(2'd0, 0, 32'hFFFFFFFF);
    check_all("R11 idle");
    for (int r = 0; r < 40; r++) begin
      do_reset();
      for (int k = 0; k < 25; k++) begin
        logic [1:0] sel = 2'($urandom_range(0, 3));
        int idx = (sel == 2'd1) ? $urandom_range(0, N + 1) : $urandom_range(0, 2);
        logic [XLEN-1:0] d = $urandom;
        if (sel == 2'd0) d = d & 32'h9F9F9F9F;
        if ($urandom_range(0, 4) == 0) begin
          idle(sel, idx, d);
          check_all("R11 sweep idle");
        end else begin
          wr(sel, idx, d);
          check_all("R2 R3 R4 R5 R6 R7 R8 R9 sweep");
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule